// File: doc/BRIEF.md
# DS3 Receive Defect and Far-End Alarm Monitor

This block watches a DS3 receive bit stream after frame alignment has already been found. On each clock where `bitValid` is high it takes one received bit. A set of position strobes from the framer tells it what kind of bit that is: F-bit, M-bit, X-bit, C-bit (with subframe and C-bit index), payload bit, or the first bit of an M-frame. For F-bits and M-bits the framer also supplies the value the bit should have.

From these inputs the block keeps five status levels: loss of signal, out of frame, idle signal, far-end receive failure, and a validated far-end alarm/control code with its 6-bit value. Each defect follows its own set and clear rule. These rules use run lengths of zeros and ones, a sliding window of F-bit errors, a history of M-frames with M-bit errors, a persistence count for idle in whole M-frames, and a vote over the last ten received alarm codewords. Every change of status can raise a one-cycle interrupt pulse, and each pulse has its own enable bit.

An M-frame ends on the valid bit that carries `mfStart`. That bit already belongs to the next M-frame. All per-frame rules are evaluated at that boundary.

Top module: `ds3_defect_mon`

## Requirements
- R1: `losState` rises on the valid bit that completes a run of 180 consecutive received zeros. While `losDisable` is high, `losState` is held at 0.
- R2: Once set, `losState` falls on the valid bit that completes a run of 60 consecutive received ones. A zero before that restarts the count.
- R3: A received F-bit is in error when it differs from `refBit`. `oofState` is 1 while at least 3 (`oofSix`=0) or at least 6 (`oofSix`=1) of the last 15 F-bits are in error.
- R4: An M-frame is errored if any M-bit in it differs from `refBit`. `oofState` is also 1 while 3 or more of the last 4 closed M-frames are errored. `oofState` is 0 only when neither the F-bit rule nor the M-frame rule holds.
- R5: An M-frame counts as idle when all three of these hold: every C-bit with `cSub`=3 is 0; it contains two X-bits that are both 1; and its payload bits follow 1,1,0,0 repeating, starting afresh with each M-frame. `idleState` sets after 63 consecutive idle M-frames and clears after 63 consecutive non-idle M-frames.
- R6: `ferfState` becomes 1 when both X-bits of an M-frame are 0, and becomes 0 when both are 1. X-bits that differ leave it unchanged.
- R7: The alarm channel is the C-bit with `cSub`=1 and `cNum`=3. A codeword is the 16-bit sequence 0, c5..c0, 0, eight 1s, received oldest first, with c5 first. A codeword is recognised only when at least 16 channel bits have arrived since the previous one. C-bits in any other position are ignored.
- R8: While no code is validated, `feacValid` sets and `feacCode` takes a code once 8 of the last 10 received codewords carry that code. `feacCode` does not change while `feacValid` stays high.
- R9: While a code is validated, `feacValid` clears once 3 of the last 10 received codewords differ from `feacCode`.
- R10: `intPulse` bits are 0 = LOS change, 1 = OOF change, 2 = idle change, 3 = FERF change, 4 = code validated, 5 = code removed. Each is a one-cycle pulse in the first cycle the new state shows, and only when the matching `intEn` bit is 1.
- R11: After reset all status outputs and `intPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| losDisable | input | 1 | Holds loss of signal off |
| oofSix | input | 1 | F-bit error threshold: 0 = 3 of 15, 1 = 6 of 15 |
| intEn | input | 6 | Per-cause interrupt enable |
| bitValid | input | 1 | A received bit is present this cycle |
| rxBit | input | 1 | Received bit value |
| refBit | input | 1 | Expected value for an F-bit or M-bit |
| isF | input | 1 | Bit is an F-bit |
| isM | input | 1 | Bit is an M-bit |
| isX | input | 1 | Bit is an X-bit |
| isC | input | 1 | Bit is a C-bit |
| cSub | input | 3 | Subframe number (1..7) of a C-bit |
| cNum | input | 2 | C-bit index within its subframe (1..3) |
| isPay | input | 1 | Bit is a payload bit |
| mfStart | input | 1 | Bit is the first bit of a new M-frame |
| losState | output | 1 | Loss of signal |
| oofState | output | 1 | Out of frame |
| idleState | output | 1 | Idle signal present |
| ferfState | output | 1 | Far-end receive failure |
| feacValid | output | 1 | An alarm code is validated |
| feacCode | output | 6 | Validated alarm code value |
| intPulse | output | 6 | Change interrupt pulses |

## Verification
The hardest behaviour to reach is at the edges of the persistence and voting rules: the 63rd idle M-frame after one broken frame, and the third mismatching codeword that lands while older matches are still leaving the ten-entry window. The stimulus builds whole M-frames from short strobe sequences. Because only the strobed bits matter, hundreds of frames cost a few thousand cycles. A broken frame is placed so that the run restarts. The alarm channel gets exact codeword mixes, including a burst of full codewords on a different C-bit position that must be ignored. Every F-bit error count from 0 to 7 in both threshold modes is swept, and so is every 4-frame M-bit error pattern.

// File: rtl/ds3mon_pkg.sv
package ds3mon_pkg;

  localparam int INT_W        = 6;
  localparam int INT_LOS      = 0;
  localparam int INT_OOF      = 1;
  localparam int INT_IDLE     = 2;
  localparam int INT_FERF     = 3;
  localparam int INT_FEAC_VAL = 4;
  localparam int INT_FEAC_RMV = 5;
  localparam int CODE_W       = 6;

  // strobes and levels handed from datapath to control
  typedef struct packed {
    logic              losSet;      // this bit completes the zero run
    logic              losClr;      // this bit completes the one run
    logic              oofCond;     // F or M window over threshold
    logic              mfClose;     // an M-frame closes on this bit
    logic              frameIdleOk; // closing frame met the idle rule
    logic              xBothZero;   // second X-bit seen, both zero
    logic              xBothOne;    // second X-bit seen, both one
    logic              feacNew;     // a full alarm codeword arrived
    logic [CODE_W-1:0] feacWord;    // its code field
  } monEvt_t;

endpackage

// File: rtl/ds3mon_datapath.sv
module ds3mon_datapath
  import ds3mon_pkg::*;
#(
  parameter int LOS_SET    = 180,
  parameter int LOS_CLR    = 60,
  parameter int F_WIN      = 15,
  parameter int OOF_THR_LO = 3,
  parameter int OOF_THR_HI = 6,
  parameter int M_WIN      = 4,
  parameter int M_THR      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       rxBit,
  input  logic       refBit,
  input  logic       isF,
  input  logic       isM,
  input  logic       isX,
  input  logic       isC,
  input  logic [2:0] cSub,
  input  logic [1:0] cNum,
  input  logic       isPay,
  input  logic       mfStart,
  input  logic       oofSix,
  output monEvt_t    evt
);

  localparam int ZW       = $clog2(LOS_SET + 1);
  localparam int OW       = $clog2(LOS_CLR + 1);
  localparam int FCW      = $clog2(F_WIN + 1);
  localparam int MCW      = $clog2(M_WIN + 1);
  localparam int FEAC_LEN = 16;
  localparam int SCW      = $clog2(FEAC_LEN + 1);

  localparam logic [ZW-1:0]  ZERO_MAX = ZW'(LOS_SET);
  localparam logic [ZW-1:0]  ZERO_HIT = ZW'(LOS_SET - 1);
  localparam logic [OW-1:0]  ONE_MAX  = OW'(LOS_CLR);
  localparam logic [OW-1:0]  ONE_HIT  = OW'(LOS_CLR - 1);
  localparam logic [SCW-1:0] SINCE_MAX = SCW'(FEAC_LEN);
  localparam logic [SCW-1:0] SINCE_HIT = SCW'(FEAC_LEN - 1);

  // ---------------- run lengths for signal loss ----------------
  logic [ZW-1:0] zeroRun;
  logic [OW-1:0] oneRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroRun <= '0;
      oneRun  <= '0;
    end else if (bitValid) begin
      if (rxBit) begin
        zeroRun <= '0;
        if (oneRun != ONE_MAX) oneRun <= oneRun + 1'b1;
      end else begin
        oneRun <= '0;
        if (zeroRun != ZERO_MAX) zeroRun <= zeroRun + 1'b1;
      end
    end
  end

  // ---------------- F-bit error window ----------------
  logic [F_WIN-1:0] fWin;
  logic [FCW-1:0]   fErrCnt, fThr;

  always_ff @(posedge clk) begin
    if (!rstN)                fWin <= '0;
    else if (bitValid && isF) fWin <= {fWin[F_WIN-2:0], rxBit ^ refBit};
  end

  assign fErrCnt = FCW'($countones(fWin));
  assign fThr    = oofSix ? FCW'(OOF_THR_HI) : FCW'(OOF_THR_LO);

  // ---------------- per-frame accumulators ----------------
  logic             inFrame;
  logic             mErrCur;
  logic [M_WIN-1:0] mHist;
  logic [MCW-1:0]   mErrCnt;
  logic [1:0]       xCnt, xCntBase;
  logic             xFirst;
  logic [1:0]       xOneCnt, xOneBase;
  logic             idleOk, idleBase;
  logic [1:0]       payPhase, payBase;
  logic             mHit, bitBad, newMf, xHit;

  assign newMf    = bitValid && mfStart;
  assign mHit     = bitValid && isM && (rxBit ^ refBit);
  assign xHit     = bitValid && isX;
  assign xCntBase = newMf ? 2'd0 : xCnt;
  assign xOneBase = newMf ? 2'd0 : xOneCnt;
  assign idleBase = newMf ? 1'b1 : idleOk;
  assign payBase  = newMf ? 2'd0 : payPhase;

  always_comb begin
    bitBad = 1'b0;
    if (bitValid) begin
      if (isC && cSub == 3'd3 && rxBit)       bitBad = 1'b1;
      if (isX && !rxBit)                      bitBad = 1'b1;
      if (isPay && (rxBit != ~payBase[1]))    bitBad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      mErrCur  <= 1'b0;
      mHist    <= '0;
      xCnt     <= '0;
      xFirst   <= 1'b0;
      xOneCnt  <= '0;
      idleOk   <= 1'b1;
      payPhase <= '0;
    end else if (bitValid) begin
      if (newMf) begin
        inFrame <= 1'b1;
        mErrCur <= mHit;
        if (inFrame) mHist <= {mHist[M_WIN-2:0], mErrCur};
      end else if (mHit) begin
        mErrCur <= 1'b1;
      end
      idleOk <= idleBase & ~bitBad;
      if (xHit && xCntBase == 2'd0) xFirst <= rxBit;
      xCnt     <= (xHit && xCntBase != 2'd2) ? xCntBase + 2'd1 : xCntBase;
      xOneCnt  <= (xHit && rxBit && xOneBase != 2'd2) ? xOneBase + 2'd1 : xOneBase;
      payPhase <= isPay ? payBase + 2'd1 : payBase;
    end
  end

  assign mErrCnt = MCW'($countones(mHist));

  // ---------------- alarm channel codeword detect ----------------
  logic [FEAC_LEN-1:0] feacSr, feacSrNext;
  logic [SCW-1:0]      sinceCnt;
  logic                feacHit, feacMatch;

  assign feacHit    = bitValid && isC && cSub == 3'd1 && cNum == 2'd3;
  assign feacSrNext = {feacSr[FEAC_LEN-2:0], rxBit};
  assign feacMatch  = feacHit && (sinceCnt >= SINCE_HIT) && !feacSrNext[15]
                      && !feacSrNext[8] && (&feacSrNext[7:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      feacSr   <= '0;
      sinceCnt <= '0;
    end else if (feacHit) begin
      feacSr <= feacSrNext;
      if (feacMatch)                  sinceCnt <= '0;
      else if (sinceCnt != SINCE_MAX) sinceCnt <= sinceCnt + 1'b1;
    end
  end

  // ---------------- strobes to control ----------------
  always_comb begin
    evt.losSet      = bitValid && !rxBit && (zeroRun >= ZERO_HIT);
    evt.losClr      = bitValid &&  rxBit && (oneRun  >= ONE_HIT);
    evt.oofCond     = (fErrCnt >= fThr) || (mErrCnt >= MCW'(M_THR));
    evt.mfClose     = newMf && inFrame;
    evt.frameIdleOk = idleOk && (xOneCnt == 2'd2);
    evt.xBothZero   = xHit && (xCntBase == 2'd1) && !xFirst && !rxBit;
    evt.xBothOne    = xHit && (xCntBase == 2'd1) &&  xFirst &&  rxBit;
    evt.feacNew     = feacMatch;
    evt.feacWord    = feacSrNext[14:9];
  end

endmodule

// File: rtl/ds3mon_ctrl.sv
module ds3mon_ctrl
  import ds3mon_pkg::*;
#(
  parameter int IDLE_MF   = 63,
  parameter int FEAC_HIST = 10,
  parameter int FEAC_SET  = 8,
  parameter int FEAC_RMV  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              losDisable,
  input  logic [INT_W-1:0]  intEn,
  input  monEvt_t           evt,
  output logic              losState,
  output logic              oofState,
  output logic              idleState,
  output logic              ferfState,
  output logic              feacValid,
  output logic [CODE_W-1:0] feacCode,
  output logic [INT_W-1:0]  intPulse
);

  localparam int IW  = $clog2(IDLE_MF + 1);
  localparam int HCW = $clog2(FEAC_HIST + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_MF - 1);

  // ---------------- next-state for the level defects ----------------
  logic losNext, ferfNext, idleNext;
  logic [IW-1:0] idleRun, idleRunNext;

  always_comb begin
    losNext = losState;
    if (losDisable)                      losNext = 1'b0;
    else if (!losState && evt.losSet)    losNext = 1'b1;
    else if ( losState && evt.losClr)    losNext = 1'b0;

    ferfNext = ferfState;
    if (evt.xBothZero)     ferfNext = 1'b1;
    else if (evt.xBothOne) ferfNext = 1'b0;

    idleNext    = idleState;
    idleRunNext = idleRun;
    if (evt.mfClose) begin
      if (evt.frameIdleOk != idleState) begin
        if (idleRun == IDLE_LAST) begin
          idleNext    = ~idleState;
          idleRunNext = '0;
        end else begin
          idleRunNext = idleRun + 1'b1;
        end
      end else begin
        idleRunNext = '0;
      end
    end
  end

  // ---------------- alarm code voting ----------------
  logic [CODE_W-1:0]    histCode [FEAC_HIST];
  logic [FEAC_HIST-1:0] histVld;
  logic [FEAC_HIST-1:0] eqNew, misOld;
  logic [HCW-1:0]       eqCnt, misCnt;
  logic                 feacSetEv, feacRmvEv;

  assign eqNew[0]  = 1'b1;
  assign misOld[0] = (evt.feacWord != feacCode);

  for (genvar gi = 1; gi < FEAC_HIST; gi++) begin : g_vote
    assign eqNew[gi]  = histVld[gi-1] && (histCode[gi-1] == evt.feacWord);
    assign misOld[gi] = histVld[gi-1] && (histCode[gi-1] != feacCode);
  end

  assign eqCnt     = HCW'($countones(eqNew));
  assign misCnt    = HCW'($countones(misOld));
  assign feacSetEv = evt.feacNew && !feacValid && (eqCnt  >= HCW'(FEAC_SET));
  assign feacRmvEv = evt.feacNew &&  feacValid && (misCnt >= HCW'(FEAC_RMV));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histVld <= '0;
      for (int i = 0; i < FEAC_HIST; i++) histCode[i] <= '0;
    end else if (evt.feacNew) begin
      histVld     <= {histVld[FEAC_HIST-2:0], 1'b1};
      histCode[0] <= evt.feacWord;
      for (int i = 1; i < FEAC_HIST; i++) histCode[i] <= histCode[i-1];
    end
  end

  // ---------------- state and interrupt registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      losState  <= 1'b0;
      oofState  <= 1'b0;
      idleState <= 1'b0;
      ferfState <= 1'b0;
      feacValid <= 1'b0;
      feacCode  <= '0;
      idleRun   <= '0;
      intPulse  <= '0;
    end else begin
      losState  <= losNext;
      oofState  <= evt.oofCond;
      idleState <= idleNext;
      idleRun   <= idleRunNext;
      ferfState <= ferfNext;
      if (feacSetEv) begin
        feacValid <= 1'b1;
        feacCode  <= evt.feacWord;
      end else if (feacRmvEv) begin
        feacValid <= 1'b0;
      end
      intPulse[INT_LOS]      <= intEn[INT_LOS]      && (losNext != losState);
      intPulse[INT_OOF]      <= intEn[INT_OOF]      && (evt.oofCond != oofState);
      intPulse[INT_IDLE]     <= intEn[INT_IDLE]     && (idleNext != idleState);
      intPulse[INT_FERF]     <= intEn[INT_FERF]     && (ferfNext != ferfState);
      intPulse[INT_FEAC_VAL] <= intEn[INT_FEAC_VAL] && feacSetEv;
      intPulse[INT_FEAC_RMV] <= intEn[INT_FEAC_RMV] && feacRmvEv;
    end
  end

endmodule

// File: rtl/ds3_defect_mon.sv
module ds3_defect_mon
  import ds3mon_pkg::*;
#(
  parameter int LOS_SET    = 180,
  parameter int LOS_CLR    = 60,
  parameter int F_WIN      = 15,
  parameter int OOF_THR_LO = 3,
  parameter int OOF_THR_HI = 6,
  parameter int M_WIN      = 4,
  parameter int M_THR      = 3,
  parameter int IDLE_MF    = 63,
  parameter int FEAC_HIST  = 10,
  parameter int FEAC_SET   = 8,
  parameter int FEAC_RMV   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       losDisable,
  input  logic       oofSix,
  input  logic [5:0] intEn,
  input  logic       bitValid,
  input  logic       rxBit,
  input  logic       refBit,
  input  logic       isF,
  input  logic       isM,
  input  logic       isX,
  input  logic       isC,
  input  logic [2:0] cSub,
  input  logic [1:0] cNum,
  input  logic       isPay,
  input  logic       mfStart,
  output logic       losState,
  output logic       oofState,
  output logic       idleState,
  output logic       ferfState,
  output logic       feacValid,
  output logic [5:0] feacCode,
  output logic [5:0] intPulse
);

  monEvt_t evt;

  ds3mon_datapath #(
    .LOS_SET(LOS_SET), .LOS_CLR(LOS_CLR), .F_WIN(F_WIN),
    .OOF_THR_LO(OOF_THR_LO), .OOF_THR_HI(OOF_THR_HI),
    .M_WIN(M_WIN), .M_THR(M_THR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .refBit(refBit), .isF(isF), .isM(isM), .isX(isX), .isC(isC),
    .cSub(cSub), .cNum(cNum), .isPay(isPay), .mfStart(mfStart),
    .oofSix(oofSix), .evt(evt)
  );

  ds3mon_ctrl #(
    .IDLE_MF(IDLE_MF), .FEAC_HIST(FEAC_HIST),
    .FEAC_SET(FEAC_SET), .FEAC_RMV(FEAC_RMV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .losDisable(losDisable), .intEn(intEn),
    .evt(evt), .losState(losState), .oofState(oofState),
    .idleState(idleState), .ferfState(ferfState),
    .feacValid(feacValid), .feacCode(feacCode), .intPulse(intPulse)
  );

endmodule

// File: rtl/ds3mon_checker.sv
module ds3mon_checker (
  input logic       clk,
  input logic       rstN,
  input logic       losDisable,
  input logic [5:0] intEn,
  input logic       bitValid,
  input logic       isX,
  input logic       mfStart,
  input logic       losState,
  input logic       idleState,
  input logic       ferfState,
  input logic       feacValid,
  input logic [5:0] feacCode,
  input logic [5:0] intPulse
);

  AST_LOS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $past(losDisable) |-> !losState); // R1

  AST_FERF_ON_XBIT: assert property (@(posedge clk) disable iff (!rstN)
    (ferfState != $past(ferfState)) |-> $past(bitValid && isX)); // R6

  AST_IDLE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (idleState != $past(idleState)) |-> $past(bitValid && mfStart)); // R5

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (feacValid && $past(feacValid)) |-> $stable(feacCode)); // R8

  AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (intPulse & ~$past(intEn)) == 6'd0); // R10

  AST_LOS_CHANGE_INT: assert property (@(posedge clk) disable iff (!rstN)
    ((losState != $past(losState)) && $past(intEn[0])) |-> intPulse[0]); // R10

endmodule

bind ds3_defect_mon ds3mon_checker u_chk (
  .clk(clk), .rstN(rstN), .losDisable(losDisable), .intEn(intEn),
  .bitValid(bitValid), .isX(isX), .mfStart(mfStart),
  .losState(losState), .idleState(idleState), .ferfState(ferfState),
  .feacValid(feacValid), .feacCode(feacCode), .intPulse(intPulse)
);

// File: tb/ds3_defect_mon_bench.sv
module ds3_defect_mon_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       losDisable = 1'b0;
  logic       oofSix = 1'b0;
  logic [5:0] intEn = 6'h3F;
  logic       bitValid = 1'b0;
  logic       rxBit = 1'b0;
  logic       refBit = 1'b0;
  logic       isF = 1'b0, isM = 1'b0, isX = 1'b0, isC = 1'b0;
  logic [2:0] cSub = 3'd0;
  logic [1:0] cNum = 2'd0;
  logic       isPay = 1'b0, mfStart = 1'b0;
  logic       losState, oofState, idleState, ferfState, feacValid;
  logic [5:0] feacCode, intPulse;

  int nChk = 0;
  int nFail = 0;
  int pulseCnt [6];
  bit finished = 0;

  always #4 clk = ~clk;

  ds3_defect_mon u_ds3_defect_mon (
    .clk(clk), .rstN(rstN), .losDisable(losDisable), .oofSix(oofSix),
    .intEn(intEn), .bitValid(bitValid), .rxBit(rxBit), .refBit(refBit),
    .isF(isF), .isM(isM), .isX(isX), .isC(isC), .cSub(cSub), .cNum(cNum),
    .isPay(isPay), .mfStart(mfStart), .losState(losState),
    .oofState(oofState), .idleState(idleState), .ferfState(ferfState),
    .feacValid(feacValid), .feacCode(feacCode), .intPulse(intPulse)
  );

  initial for (int i = 0; i < 6; i++) pulseCnt[i] = 0;

  always @(negedge clk)
    for (int i = 0; i < 6; i++) if (intPulse[i]) pulseCnt[i] = pulseCnt[i] + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drv(input logic b, input logic f, input logic m, input logic x,
                     input logic c, input logic [2:0] sub, input logic [1:0] num,
                     input logic p, input logic mf, input logic r);
    @(negedge clk);
    bitValid = 1'b1; rxBit = b; isF = f; isM = m; isX = x; isC = c;
    cSub = sub; cNum = num; isPay = p; mfStart = mf; refBit = r;
    @(negedge clk);
    bitValid = 1'b0; isF = 1'b0; isM = 1'b0; isX = 1'b0; isC = 1'b0;
    isPay = 1'b0; mfStart = 1'b0;
  endtask

  task automatic dBit(input logic b);   drv(b, 0,0,0,0, 3'd0, 2'd0, 0,0,0); endtask
  task automatic fBit(input logic err); drv(~err, 1,0,0,0, 3'd0, 2'd0, 0,0,1); endtask
  task automatic mBit(input logic err); drv(~err, 0,1,0,0, 3'd0, 2'd0, 0,0,1); endtask
  task automatic xBit(input logic b);   drv(b, 0,0,1,0, 3'd0, 2'd0, 0,0,0); endtask
  task automatic cBit(input logic [2:0] s, input logic [1:0] n, input logic b);
    drv(b, 0,0,0,1, s, n, 0,0,0);
  endtask
  task automatic pBit(input logic b);   drv(b, 0,0,0,0, 3'd0, 2'd0, 1,0,0); endtask
  task automatic mfMark();              drv(1, 0,0,0,0, 3'd0, 2'd0, 0,1,0); endtask
  task automatic settle();              repeat (3) @(negedge clk); endtask

  // kind 0 = idle frame, 1 = C-bit set in subframe 3, 2 = X-bits differ, 3 = payload broken
  task automatic idleFrame(input int kind);
    xBit(1'b1);
    xBit(kind == 2 ? 1'b0 : 1'b1);
    cBit(3'd3, 2'd1, 1'b0);
    cBit(3'd3, 2'd2, kind == 1 ? 1'b1 : 1'b0);
    cBit(3'd3, 2'd3, 1'b0);
    for (int i = 0; i < 8; i++)
      pBit(kind == 3 ? logic'(i % 2) : logic'((i % 4) < 2));
    mfMark();
  endtask

  task automatic feacWord(input logic [5:0] code, input logic [2:0] s, input logic [1:0] n);
    cBit(s, n, 1'b0);
    for (int i = 5; i >= 0; i--) cBit(s, n, code[i]);
    cBit(s, n, 1'b0);
    for (int i = 0; i < 8; i++) cBit(s, n, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int base, expF, expO;
    logic [1:0] xa, xb;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R11 reset state
    chk("R11 status after reset", {losState, oofState, idleState, ferfState, feacValid}, 0);
    chk("R11 interrupts after reset", int'(intPulse), 0);

    // R1 / R2 loss of signal
    base = pulseCnt[0];
    for (int i = 0; i < 179; i++) dBit(1'b0);
    settle(); chk("R1 179 zeros no LOS", losState, 0);
    dBit(1'b0);
    settle(); chk("R1 180th zero sets LOS", losState, 1);
    for (int i = 0; i < 59; i++) dBit(1'b1);
    dBit(1'b0);
    settle(); chk("R2 59 ones then zero keeps LOS", losState, 1);
    for (int i = 0; i < 59; i++) dBit(1'b1);
    settle(); chk("R2 59 ones keeps LOS", losState, 1);
    dBit(1'b1);
    settle(); chk("R2 60th one clears LOS", losState, 0);
    chk("R10 LOS change pulses", pulseCnt[0] - base, 2);
    losDisable = 1'b1;
    for (int i = 0; i < 200; i++) dBit(1'b0);
    settle(); chk("R1 disabled LOS stays low", losState, 0);
    dBit(1'b1);
    losDisable = 1'b0;

    // R3 F-bit window sweep in both threshold modes
    for (int md = 0; md < 2; md++) begin
      oofSix = logic'(md);
      for (int k = 0; k < 8; k++) begin
        for (int i = 0; i < 15; i++) fBit(1'b0);
        for (int i = 0; i < k; i++) fBit(1'b1);
        settle();
        expO = (k >= (md ? 6 : 3)) ? 1 : 0;
        chk($sformatf("R3 mode %0d errors %0d", md, k), oofState, expO);
      end
      for (int i = 0; i < 15; i++) fBit(1'b0);
      settle(); chk("R3 clean window clears OOF", oofState, 0);
    end
    oofSix = 1'b0;

    // R4 M-frame error history, every 4-frame pattern
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 4; i++) begin mBit(1'b0); mfMark(); end
      for (int i = 0; i < 4; i++) begin mBit(logic'((p >> i) & 1)); mfMark(); end
      settle();
      chk($sformatf("R4 pattern %0d", p), oofState, ($countones(p[3:0]) >= 3) ? 1 : 0);
    end
    for (int i = 0; i < 4; i++) begin mBit(1'b0); mfMark(); end
    settle(); chk("R4 clean history clears OOF", oofState, 0);

    // R6 far-end receive failure over X-bit pairs
    expF = ferfState;
    for (int s = 0; s < 8; s++) begin
      xa = (s == 0 || s == 1 || s == 6) ? 2'd0 : 2'd1;
      xb = (s == 0 || s == 2 || s == 4 || s == 6) ? 2'd0 : 2'd1;
      if (s == 4) xa = 2'd1;
      if (s == 5) begin xa = 2'd0; xb = 2'd1; end
      base = pulseCnt[3];
      xBit(xa[0]); xBit(xb[0]); mfMark();
      settle();
      if (xa[0] == 1'b0 && xb[0] == 1'b0) begin
        chk($sformatf("R10 FERF pulse step %0d", s), pulseCnt[3] - base, (expF == 0) ? 1 : 0);
        expF = 1;
      end else if (xa[0] == 1'b1 && xb[0] == 1'b1) begin
        chk($sformatf("R10 FERF pulse step %0d", s), pulseCnt[3] - base, (expF == 1) ? 1 : 0);
        expF = 0;
      end
      chk($sformatf("R6 step %0d x=%0d%0d", s, xa[0], xb[0]), ferfState, expF);
    end
    // R10 mask: change with enable off gives no pulse
    intEn[3] = 1'b0;
    base = pulseCnt[3];
    xBit(1'b0); xBit(1'b0); mfMark(); settle();
    chk("R6 FERF set while masked", ferfState, 1);
    chk("R10 masked FERF no pulse", pulseCnt[3] - base, 0);
    intEn[3] = 1'b1;
    xBit(1'b1); xBit(1'b1); mfMark(); settle();
    chk("R6 FERF cleared", ferfState, 0);

    // R5 idle persistence
    base = pulseCnt[2];
    for (int i = 0; i < 30; i++) idleFrame(0);
    idleFrame(1);
    for (int i = 0; i < 62; i++) idleFrame(0);
    settle(); chk("R5 62 idle frames after a break", idleState, 0);
    idleFrame(0);
    settle(); chk("R5 63rd idle frame sets idle", idleState, 1);
    for (int i = 0; i < 62; i++) idleFrame(1 + (i % 3));
    settle(); chk("R5 62 non-idle frames keep idle", idleState, 1);
    idleFrame(3);
    settle(); chk("R5 63rd non-idle frame clears idle", idleState, 0);
    chk("R10 idle change pulses", pulseCnt[2] - base, 2);

    // R7 / R8 / R9 alarm code voting
    base = pulseCnt[4];
    for (int i = 0; i < 7; i++) feacWord(6'h15, 3'd1, 2'd3);
    settle(); chk("R8 seven codewords not validated", feacValid, 0);
    feacWord(6'h15, 3'd1, 2'd3);
    settle(); chk("R8 eighth codeword validates", feacValid, 1);
    chk("R8 validated code value", feacCode, 'h15);
    chk("R10 validation pulse", pulseCnt[4] - base, 1);
    for (int i = 0; i < 8; i++) feacWord(6'h2A, 3'd2, 2'd3);
    settle(); chk("R7 other C-bit position ignored", {feacValid, feacCode}, {1'b1, 6'h15});
    base = pulseCnt[5];
    feacWord(6'h2A, 3'd1, 2'd3);
    feacWord(6'h2A, 3'd1, 2'd3);
    settle(); chk("R9 two mismatches keep code", feacValid, 1);
    feacWord(6'h2A, 3'd1, 2'd3);
    settle(); chk("R9 third mismatch removes code", feacValid, 0);
    chk("R10 removal pulse", pulseCnt[5] - base, 1);
    for (int i = 0; i < 7; i++) feacWord(6'h07, 3'd1, 2'd3);
    settle(); chk("R8 seven of new code not validated", feacValid, 0);
    feacWord(6'h07, 3'd1, 2'd3);
    settle(); chk("R8 new code validated", {feacValid, feacCode}, {1'b1, 6'h07});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule